// File: doc/BRIEF.md
# Windowed Auto-Incrementing RAM Slave

This block is a slave on a simple synchronous control bus. It gives a host access to a dual-port block memory of 32-bit words while taking up only two bus addresses. A pointer register at one address selects a memory location. A data window at the other address reads the word at that location. Each access to the data window moves the pointer on by one word. A host can therefore drain a whole buffer with one non-incrementing block read aimed at the data window.

The other memory port belongs to a data source, such as a detector front end or a test generator. It writes words on its own clock. The usual pattern is that the source fills the buffer, the host sets the pointer to the start and then streams the buffer out.

Every bus access is acknowledged exactly one bus cycle after it is accepted. This gives the synchronous memory read its cycle of latency. While the acknowledge is high, a strobe that stays high is not taken as a new access, so a held strobe can never advance the pointer twice for one transfer.

Top module: `windowed_ram_port`

## Requirements
- R1: After reset, the acknowledge output is low and the pointer is zero.
- R2: A write to offset 0 (busAddr = 0) loads the pointer from the low DEPTH_LOG2 bits of the write data. The upper bits are dropped. A read of offset 0 returns the pointer, zero-extended to 32 bits.
- R3: A read of offset 1 (busAddr = 1) returns the memory word at the current pointer and advances the pointer by exactly one.
- R4: An access is accepted on a rising edge where the strobe is high and the acknowledge is low. The acknowledge is high during the next cycle only. A strobe held through the acknowledge cycle is not accepted again until the cycle after that.
- R5: With the strobe held high, back-to-back reads of offset 1 return consecutive memory words in ascending address order, one word for each acknowledge.
- R6: Advancing past location 2^DEPTH_LOG2 − 1 wraps the pointer to 0.
- R7: A write to offset 1 advances the pointer by one and leaves the memory contents unchanged.
- R8: On a rising srcClk edge where srcWe is high, srcData is stored at location srcAddr.
- R9: While the strobe is low, no acknowledge is produced and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Bus clock |
| busRst | input | 1 | Synchronous reset, active high |
| busAddr | input | 1 | Register offset: 0 selects the pointer, 1 selects the data window |
| busWdata | input | 32 | Bus write data |
| busStb | input | 1 | Access strobe |
| busWe | input | 1 | High for a write, low for a read |
| busRdata | output | 32 | Read data, valid while busAck is high |
| busAck | output | 1 | Access acknowledge |
| srcClk | input | 1 | Data-source clock |
| srcWe | input | 1 | Data-source write enable |
| srcAddr | input | DEPTH_LOG2 | Data-source write location |
| srcData | input | 32 | Data-source write word |

## Verification
Every bus result is due in the cycle after its strobe is accepted. The acknowledge must be high at the first falling edge after that acceptance and low again at the second falling edge. The bench drives strobe, address and write data on a falling edge and checks the acknowledge at the next two falling edges. A monitor pops the expected word from a queue when it sees the acknowledge and compares the read data in that same cycle. Source writes land on the rising srcClk edge that follows their falling-edge drive, so the bench realigns to the bus clock before reading them back.

// File: rtl/win_pkg.sv
package win_pkg;

  // Register offsets on the bus side
  localparam logic OFFS_PTR  = 1'b0;
  localparam logic OFFS_DATA = 1'b1;

  // Strobes from control to datapath, valid in the acceptance cycle
  typedef struct packed {
    logic ptrLoad;   // load pointer from write data
    logic ptrInc;    // advance pointer by one word
    logic capture;   // register read data for the acknowledge cycle
    logic selData;   // capture memory word (1) or pointer value (0)
  } winCtl_t;

endpackage

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_pkg::*;
(
  input  logic    busClk,
  input  logic    busRst,
  input  logic    busAddr,
  input  logic    busStb,
  input  logic    busWe,
  output winCtl_t ctl,
  output logic    busAck
);

  logic ackQ;
  logic accept;

  // A new access is only taken when no acknowledge is in flight
  assign accept = busStb && !ackQ && !busRst;

  always_comb begin
    ctl         = '0;
    ctl.ptrLoad = accept && busWe && (busAddr == OFFS_PTR);
    ctl.ptrInc  = accept && (busAddr == OFFS_DATA);
    ctl.capture = accept && !busWe;
    ctl.selData = (busAddr == OFFS_DATA);
  end

  always_ff @(posedge busClk) begin
    if (busRst) ackQ <= 1'b0;
    else        ackQ <= accept;
  end

  assign busAck = ackQ;

  // R4
  ack_after_accept_chk: assert property (@(posedge busClk) disable iff (busRst)
    (busStb && !busAck) |=> busAck);

  // R4
  ack_single_chk: assert property (@(posedge busClk) disable iff (busRst)
    busAck |=> !busAck);

  // R9
  no_stb_no_ack_chk: assert property (@(posedge busClk) disable iff (busRst)
    !busStb |=> !busAck);

endmodule

// File: rtl/win_datapath.sv
module win_datapath
  import win_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  busClk,
  input  logic                  busRst,
  input  logic [DATA_W-1:0]     busWdata,
  input  winCtl_t               ctl,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  srcClk,
  input  logic                  srcWe,
  input  logic [DEPTH_LOG2-1:0] srcAddr,
  input  logic [DATA_W-1:0]     srcData
);

  localparam int PTR_W = DEPTH_LOG2;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PAD_W = DATA_W - PTR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] rdQ;

  // Source-side write port, owned entirely by the data-source clock
  always_ff @(posedge srcClk) begin
    if (srcWe) memArray[srcAddr] <= srcData;
  end

  // Pointer: load or advance; width-limited add wraps at the last location
  always_ff @(posedge busClk) begin
    if (busRst)           ptrQ <= '0;
    else if (ctl.ptrLoad) ptrQ <= busWdata[PTR_W-1:0];
    else if (ctl.ptrInc)  ptrQ <= ptrQ + 1'b1;
  end

  // Bus-side read port: one registered stage, presented with the acknowledge
  always_ff @(posedge busClk) begin
    if (busRst)           rdQ <= '0;
    else if (ctl.capture) rdQ <= ctl.selData ? memArray[ptrQ]
                                             : {{PAD_W{1'b0}}, ptrQ};
  end

  assign busRdata = rdQ;

  // R3 R6
  ptr_step_chk: assert property (@(posedge busClk) disable iff (busRst)
    ctl.ptrInc |=> ptrQ == PTR_W'($past(ptrQ) + 1'b1));

  // R2
  ptr_load_chk: assert property (@(posedge busClk) disable iff (busRst)
    ctl.ptrLoad |=> ptrQ == $past(busWdata[PTR_W-1:0]));

  // R9
  ptr_hold_chk: assert property (@(posedge busClk) disable iff (busRst)
    !(ctl.ptrInc || ctl.ptrLoad) |=> $stable(ptrQ));

  // R4
  ctl_excl_chk: assert property (@(posedge busClk) disable iff (busRst)
    $onehot0({ctl.ptrInc, ctl.ptrLoad}));

endmodule

// File: rtl/windowed_ram_port.sv
module windowed_ram_port
  import win_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  busClk,
  input  logic                  busRst,
  input  logic                  busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  busStb,
  input  logic                  busWe,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  busAck,
  input  logic                  srcClk,
  input  logic                  srcWe,
  input  logic [DEPTH_LOG2-1:0] srcAddr,
  input  logic [DATA_W-1:0]     srcData
);

  winCtl_t ctl;

  win_ctrl ctrl_i (
    .busClk  (busClk),
    .busRst  (busRst),
    .busAddr (busAddr),
    .busStb  (busStb),
    .busWe   (busWe),
    .ctl     (ctl),
    .busAck  (busAck)
  );

  win_datapath #(
    .DATA_W     (DATA_W),
    .DEPTH_LOG2 (DEPTH_LOG2)
  ) dp_i (
    .busClk   (busClk),
    .busRst   (busRst),
    .busWdata (busWdata),
    .ctl      (ctl),
    .busRdata (busRdata),
    .srcClk   (srcClk),
    .srcWe    (srcWe),
    .srcAddr  (srcAddr),
    .srcData  (srcData)
  );

endmodule

// File: tb/windowed_ram_port_tb_top.sv
module windowed_ram_port_tb_top;

  localparam int BUS_PERIOD = 10;
  localparam int SRC_PERIOD = 14;
  localparam int DEPTH_LOG2 = 8;
  localparam int DEPTH      = 1 << DEPTH_LOG2;

  logic                  busClk = 1'b0;
  logic                  srcClk = 1'b0;
  logic                  busRst = 1'b1;
  logic                  busAddr = 1'b0;
  logic [31:0]           busWdata = '0;
  logic                  busStb = 1'b0;
  logic                  busWe = 1'b0;
  logic [31:0]           busRdata;
  logic                  busAck;
  logic                  srcWe = 1'b0;
  logic [DEPTH_LOG2-1:0] srcAddr = '0;
  logic [31:0]           srcData = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] expQ[$];
  logic        readQ[$];
  string       tagQ[$];
  logic [31:0] shadow [DEPTH];

  initial forever #(BUS_PERIOD / 2) busClk = ~busClk;
  initial forever #(SRC_PERIOD / 2) srcClk = ~srcClk;

  windowed_ram_port #(.DATA_W(32), .DEPTH_LOG2(DEPTH_LOG2)) dut_i (
    .busClk, .busRst, .busAddr, .busWdata, .busStb, .busWe,
    .busRdata, .busAck, .srcClk, .srcWe, .srcAddr, .srcData
  );

  function automatic logic [31:0] patt(int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0007);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling bus edge, returns at the falling edge where
  // the next access may be presented.
  task automatic busAccess(logic addr, logic we, logic [31:0] wdata,
                           logic [31:0] exp, bit hold, string tag);
    busAddr  = addr;
    busWe    = we;
    busWdata = wdata;
    busStb   = 1'b1;
    expQ.push_back(exp);
    readQ.push_back(!we);
    tagQ.push_back(tag);
    @(negedge busClk);
    check(busAck === 1'b1, "R4 ack one cycle after accept", 32'(busAck), 32'd1);
    if (!hold) busStb = 1'b0;
    @(negedge busClk);
    check(busAck === 1'b0, "R4 ack lasts one cycle", 32'(busAck), 32'd0);
  endtask

  task automatic srcWrite(int addr, logic [31:0] data);
    @(negedge srcClk);
    srcAddr = addr[DEPTH_LOG2-1:0];
    srcData = data;
    srcWe   = 1'b1;
    @(negedge srcClk);
    srcWe   = 1'b0;
    shadow[addr] = data;
  endtask

  // Monitor: pops the expected result when an acknowledge is seen
  always @(negedge busClk) begin
    if (!busRst && busAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected ack", 32'(busAck), 32'd0);
      end else begin
        logic [31:0] e;
        logic        r;
        string       t;
        e = expQ.pop_front();
        r = readQ.pop_front();
        t = tagQ.pop_front();
        if (r) check(busRdata === e, t, busRdata, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge busClk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge busClk);
    busRst = 1'b0;
    check(busAck === 1'b0, "R1 ack low after reset", 32'(busAck), 32'd0);
    busAccess(1'b0, 1'b0, '0, 32'd0, 1'b0, "R1 pointer zero after reset");

    // R8: source port fills the whole memory
    for (int i = 0; i < DEPTH; i++) srcWrite(i, patt(i));
    @(negedge busClk);

    // R2: load and read back, upper bits dropped
    busAccess(1'b0, 1'b1, 32'd5, '0, 1'b0, "R2 load");
    busAccess(1'b0, 1'b0, '0, 32'd5, 1'b0, "R2 pointer read back");
    busAccess(1'b0, 1'b1, 32'hFFFF_FF03, '0, 1'b0, "R2 load wide");
    busAccess(1'b0, 1'b0, '0, 32'd3, 1'b0, "R2 upper bits dropped");

    // R5 R3: held-strobe block read of eight words
    for (int k = 0; k < 8; k++)
      busAccess(1'b1, 1'b0, '0, shadow[3 + k], k != 7, "R5 streamed word");
    busAccess(1'b0, 1'b0, '0, 32'd11, 1'b0, "R3 pointer advanced once per ack");

    // R6: wrap past the last location
    busAccess(1'b0, 1'b1, 32'(DEPTH - 2), '0, 1'b0, "R6 load near end");
    busAccess(1'b1, 1'b0, '0, shadow[DEPTH - 2], 1'b1, "R6 word before end");
    busAccess(1'b1, 1'b0, '0, shadow[DEPTH - 1], 1'b1, "R6 last word");
    busAccess(1'b1, 1'b0, '0, shadow[0], 1'b0, "R6 wrapped to location 0");
    busAccess(1'b0, 1'b0, '0, 32'd1, 1'b0, "R6 pointer after wrap");

    // R7: data-window write advances pointer, memory unchanged
    busAccess(1'b1, 1'b1, 32'hDEAD_BEEF, '0, 1'b0, "R7 window write");
    busAccess(1'b0, 1'b0, '0, 32'd2, 1'b0, "R7 pointer advanced by write");
    busAccess(1'b0, 1'b1, 32'd1, '0, 1'b0, "R7 reload");
    busAccess(1'b1, 1'b0, '0, shadow[1], 1'b0, "R7 memory unchanged");

    // R9: idle strobe gives no ack and keeps the pointer
    for (int k = 0; k < 6; k++) begin
      @(negedge busClk);
      check(busAck === 1'b0, "R9 no ack while idle", 32'(busAck), 32'd0);
    end
    busAccess(1'b0, 1'b0, '0, 32'd2, 1'b0, "R9 pointer kept while idle");

    // R8: source overwrite is visible to the bus
    srcWrite(40, 32'h1234_5678);
    @(negedge busClk);
    busAccess(1'b0, 1'b1, 32'd40, '0, 1'b0, "R8 load");
    busAccess(1'b1, 1'b0, '0, 32'h1234_5678, 1'b0, "R8 source overwrite");

    repeat (3) @(negedge busClk);
    check(expQ.size() == 0, "R4 every access acknowledged", 32'(expQ.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule